// File: doc/BRIEF.md
# Debug trace instruction counter

This block lets a debugger run a known number of instructions at full speed and then take the processor back into debug mode. While the processor is halted, the debugger writes a count. Trace mode is then enabled and the processor is released. The block counts every retired instruction, interrupt service code included. When the count runs out, it raises a debug-entry request and sets a sticky trace-hit status bit.

The count has an off-by-one meaning. A loaded value N lets N+1 instructions retire, because the request fires on the instruction after the one that brings the count to zero. A loaded zero is legal only in sequential-breakpoint mode, where it means exactly one instruction. In any other mode a loaded zero is refused: it raises a load-error flag and tracing does not start. A separate control input makes the block ask for debug entry straight out of reset.

Top module: `dtc_trace_counter`

## Requirements
- R1: After reset with `halt_on_reset` low, `dbg_req`, `trace_hit` and `load_err` are 0 and `cnt_rd_data` reads 0.
- R2: A count write (`cnt_wr_en` high) is taken only while `in_debug` is high. A write while `in_debug` is low leaves `cnt_rd_data` unchanged.
- R3: While trace mode is armed, `trace_en` is high and `in_debug` is low, each `instr_done` pulse lowers `cnt_rd_data` by one. With `trace_en` low the count holds.
- R4: With `seq_bkpt_en` low, a loaded count N ≥ 1 raises `dbg_req` in the cycle after the (N+1)th `instr_done` pulse, and not earlier.
- R5: With `seq_bkpt_en` high, a loaded count of 0 raises `dbg_req` in the cycle after the first `instr_done` pulse.
- R6: Writing 0 while `seq_bkpt_en` is low sets `load_err` and arms nothing, so no `dbg_req` follows. A later legal write clears `load_err`.
- R7: `trace_hit` rises together with a trace-caused `dbg_req`. It stays high until `sts_clr` is pulsed or `in_debug` falls.
- R8: `dbg_req` stays high until `in_debug` is seen high, and it is low one cycle later.
- R9: If `halt_on_reset` is high while reset is applied, `dbg_req` is high from the first cycle after reset and follows the R8 hold rule. `trace_hit` stays 0.
- R10: After a trace request, further instructions cause no new request until the count is loaded again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_wr_en | input | 1 | Count register write strobe |
| cnt_wr_data | input | CNT_W | Count value to load |
| cnt_rd_data | output | CNT_W | Live count value |
| trace_en | input | 1 | Trace mode enable |
| seq_bkpt_en | input | 1 | Sequential-breakpoint mode (allows a zero count) |
| halt_on_reset | input | 1 | Request debug entry when reset is released |
| in_debug | input | 1 | Processor is in debug mode |
| instr_done | input | 1 | One-cycle pulse per retired instruction |
| sts_clr | input | 1 | Clears `trace_hit` |
| dbg_req | output | 1 | Debug-mode entry request |
| trace_hit | output | 1 | Sticky: request caused by the trace count |
| load_err | output | 1 | Last count write was an illegal zero |

## Verification
The hardest situation to reach is the exact fire instruction. The request must come on the pulse after the count reaches zero, not on the pulse that makes it zero. A related case is that the block must stay silent afterwards, once the count sits at zero. Each trace task loads a small count and sends `instr_done` pulses one at a time. It samples the count and `dbg_req` after every pulse, so both an early fire and a missing extra step show up. It then keeps pulsing with nothing reloaded. The reset-time request is reached by applying reset a second time with `halt_on_reset` high and the processor outside debug mode.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
   typedef enum logic [1:0] {
      LD_NONE = 2'd0,
      LD_OK   = 2'd1,
      LD_BAD  = 2'd2
   } load_kind_e;

   // A write counts only in debug mode; zero is legal only with sequential mode.
   function automatic load_kind_e classify_load(input logic dbg,
                                                input logic wr,
                                                input logic is_zero,
                                                input logic seq_mode);
      if (!(dbg && wr))            return LD_NONE;
      else if (is_zero && !seq_mode) return LD_BAD;
      else                         return LD_OK;
   endfunction
endpackage

// File: rtl/dtc_load_qual.sv
module dtc_load_qual
   import dtc_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             in_debug,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             seq_mode,
   output load_kind_e       load_kind
);
   localparam logic [CNT_W-1:0] ZERO = '0;

   always_comb begin
      load_kind = classify_load(in_debug, wr_en, (wr_data == ZERO), seq_mode);
   end
endmodule

// File: rtl/dtc_down_cnt.sv
module dtc_down_cnt
   import dtc_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  load_kind_e       load_kind,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             step,
   output logic [CNT_W-1:0] count,
   output logic             armed,
   output logic             fire
);
   localparam logic [CNT_W-1:0] ZERO = '0;
   localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

   logic at_zero;
   assign at_zero = (count == ZERO);
   // The step taken while already at zero is the extra one: it fires.
   assign fire    = armed && step && at_zero;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= ZERO;
         armed <= 1'b0;
      end else begin
         case (load_kind)
            LD_OK: begin
               count <= wr_data;
               armed <= 1'b1;
            end
            LD_BAD: armed <= 1'b0;
            default: begin
               if (armed && step) begin
                  if (at_zero) armed <= 1'b0;
                  else         count <= count - ONE;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/dtc_req_ctrl.sv
module dtc_req_ctrl
   import dtc_pkg::*;
#(
   parameter bit RST_REQ_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       halt_on_reset,
   input  logic       in_debug,
   input  logic       fire,
   input  logic       sts_clr,
   input  load_kind_e load_kind,
   output logic       dbg_req,
   output logic       trace_hit,
   output logic       load_err
);
   logic trc_req;
   logic dbg_q;
   logic rst_pend;
   logic dbg_exit;

   assign dbg_exit = dbg_q && !in_debug;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trc_req   <= 1'b0;
         trace_hit <= 1'b0;
         load_err  <= 1'b0;
         dbg_q     <= 1'b0;
      end else begin
         dbg_q <= in_debug;
         if (fire)          trc_req <= 1'b1;
         else if (in_debug) trc_req <= 1'b0;
         if (fire)                      trace_hit <= 1'b1;
         else if (sts_clr || dbg_exit) trace_hit <= 1'b0;
         if (load_kind == LD_BAD)      load_err <= 1'b1;
         else if (load_kind == LD_OK)  load_err <= 1'b0;
      end
   end

   generate
      if (RST_REQ_EN) begin : g_rst_req
         // Sampled while reset is held, so the last value before release wins.
         always_ff @(posedge clk) begin
            if (!rst_n)        rst_pend <= halt_on_reset;
            else if (in_debug) rst_pend <= 1'b0;
         end
      end else begin : g_no_rst_req
         assign rst_pend = 1'b0;
      end
   endgenerate

   assign dbg_req = trc_req || rst_pend;
endmodule

// File: rtl/dtc_trace_counter.sv
module dtc_trace_counter
   import dtc_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter bit RST_REQ_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_wr_en,
   input  logic [CNT_W-1:0] cnt_wr_data,
   output logic [CNT_W-1:0] cnt_rd_data,
   input  logic             trace_en,
   input  logic             seq_bkpt_en,
   input  logic             halt_on_reset,
   input  logic             in_debug,
   input  logic             instr_done,
   input  logic             sts_clr,
   output logic             dbg_req,
   output logic             trace_hit,
   output logic             load_err
);
   initial begin
      if (CNT_W < 2 || CNT_W > 32) $error("dtc_trace_counter: CNT_W must be 2..32");
   end

   load_kind_e load_kind;
   logic       step;
   logic       armed;
   logic       fire;

   assign step = trace_en && !in_debug && instr_done;

   dtc_load_qual #(.CNT_W(CNT_W)) u_qual (
      .in_debug (in_debug),
      .wr_en    (cnt_wr_en),
      .wr_data  (cnt_wr_data),
      .seq_mode (seq_bkpt_en),
      .load_kind(load_kind)
   );

   dtc_down_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_kind(load_kind),
      .wr_data  (cnt_wr_data),
      .step     (step),
      .count    (cnt_rd_data),
      .armed    (armed),
      .fire     (fire)
   );

   dtc_req_ctrl #(.RST_REQ_EN(RST_REQ_EN)) u_req (
      .clk          (clk),
      .rst_n        (rst_n),
      .halt_on_reset(halt_on_reset),
      .in_debug     (in_debug),
      .fire         (fire),
      .sts_clr      (sts_clr),
      .load_kind    (load_kind),
      .dbg_req      (dbg_req),
      .trace_hit    (trace_hit),
      .load_err     (load_err)
   );
endmodule

// File: rtl/dtc_trace_counter_chk.sv
module dtc_trace_counter_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cnt_wr_en,
   input logic [CNT_W-1:0] cnt_wr_data,
   input logic [CNT_W-1:0] cnt_rd_data,
   input logic             trace_en,
   input logic             seq_bkpt_en,
   input logic             in_debug,
   input logic             instr_done,
   input logic             dbg_req,
   input logic             trace_hit,
   input logic             load_err,
   input logic             armed
);
   localparam logic [CNT_W-1:0] ZERO = '0;

   AST_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_debug && !(trace_en && instr_done)) |=> $stable(cnt_rd_data)); // R2

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_debug && trace_en && instr_done && armed && cnt_rd_data != ZERO)
      |=> (cnt_rd_data == $past(cnt_rd_data) - 1'b1)); // R3

   AST_ZERO_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
      (in_debug && cnt_wr_en && cnt_wr_data == ZERO && !seq_bkpt_en)
      |=> (load_err && !armed)); // R6

   AST_HIT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trace_hit) |-> dbg_req); // R7

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_req && !in_debug) |=> dbg_req); // R8

   AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      in_debug |=> !dbg_req); // R8
endmodule

bind dtc_trace_counter dtc_trace_counter_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cnt_wr_en  (cnt_wr_en),
   .cnt_wr_data(cnt_wr_data),
   .cnt_rd_data(cnt_rd_data),
   .trace_en   (trace_en),
   .seq_bkpt_en(seq_bkpt_en),
   .in_debug   (in_debug),
   .instr_done (instr_done),
   .dbg_req    (dbg_req),
   .trace_hit  (trace_hit),
   .load_err   (load_err),
   .armed      (armed)
);

// File: tb/dtc_trace_counter_tb.sv
module dtc_trace_counter_tb;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cnt_wr_en = 1'b0;
   logic [W-1:0] cnt_wr_data = '0;
   logic [W-1:0] cnt_rd_data;
   logic         trace_en = 1'b0;
   logic         seq_bkpt_en = 1'b0;
   logic         halt_on_reset = 1'b0;
   logic         in_debug = 1'b1;
   logic         instr_done = 1'b0;
   logic         sts_clr = 1'b0;
   logic         dbg_req;
   logic         trace_hit;
   logic         load_err;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   dtc_trace_counter #(.CNT_W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
      .cnt_rd_data(cnt_rd_data), .trace_en(trace_en), .seq_bkpt_en(seq_bkpt_en),
      .halt_on_reset(halt_on_reset), .in_debug(in_debug), .instr_done(instr_done),
      .sts_clr(sts_clr), .dbg_req(dbg_req), .trace_hit(trace_hit), .load_err(load_err)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic write_cnt(input logic [W-1:0] v);
      cnt_wr_en = 1'b1; cnt_wr_data = v;
      @(negedge clk);
      cnt_wr_en = 1'b0;
   endtask

   task automatic instr();
      instr_done = 1'b1;
      @(negedge clk);
      instr_done = 1'b0;
   endtask

   task automatic do_reset(input logic hor);
      rst_n = 1'b0; halt_on_reset = hor;
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      do_reset(1'b0);
      chk("R1", "dbg_req", dbg_req, 0);
      chk("R1", "trace_hit", trace_hit, 0);
      chk("R1", "load_err", load_err, 0);
      chk("R1", "count", cnt_rd_data, 0);
   endtask

   task automatic t_write_gate();
      in_debug = 1'b1; trace_en = 1'b0;
      write_cnt(8'd5);
      chk("R2", "count after debug write", cnt_rd_data, 5);
      in_debug = 1'b0; @(negedge clk);
      write_cnt(8'd9);
      chk("R2", "count after ignored write", cnt_rd_data, 5);
      in_debug = 1'b1; @(negedge clk);
   endtask

   task automatic t_hold_disabled();
      in_debug = 1'b1; trace_en = 1'b0; seq_bkpt_en = 1'b0;
      write_cnt(8'd4);
      in_debug = 1'b0; @(negedge clk);
      instr(); instr(); instr();
      chk("R3", "count with trace off", cnt_rd_data, 4);
      in_debug = 1'b1; @(negedge clk);
   endtask

   task automatic t_count(input int n);
      int fired_early = 0;
      in_debug = 1'b1; seq_bkpt_en = 1'b0;
      write_cnt(n[W-1:0]);
      trace_en = 1'b1; in_debug = 1'b0; @(negedge clk);
      for (int i = 1; i <= n; i++) begin
         instr();
         if (dbg_req) fired_early++;
         chk("R3", "count after step", cnt_rd_data, n - i);
      end
      chk("R4", "no request before extra step", fired_early, 0);
      instr();
      chk("R4", "request after N+1 instructions", dbg_req, 1);
      chk("R7", "trace_hit with request", trace_hit, 1);
      idle(3);
      chk("R8", "request held out of debug", dbg_req, 1);
      instr(); instr();
      chk("R10", "still single request state", dbg_req, 1);
      in_debug = 1'b1; @(negedge clk);
      chk("R8", "request dropped in debug", dbg_req, 0);
      chk("R7", "trace_hit sticky in debug", trace_hit, 1);
   endtask

   task automatic t_no_refire();
      in_debug = 1'b0; @(negedge clk);
      chk("R7", "trace_hit cleared by debug exit", trace_hit, 0);
      for (int i = 0; i < 6; i++) instr();
      chk("R10", "no request without reload", dbg_req, 0);
      in_debug = 1'b1; @(negedge clk);
   endtask

   task automatic t_sts_clr();
      t_count(1);
      sts_clr = 1'b1; @(negedge clk); sts_clr = 1'b0;
      chk("R7", "trace_hit cleared by sts_clr", trace_hit, 0);
   endtask

   task automatic t_seq_zero();
      in_debug = 1'b1; seq_bkpt_en = 1'b1;
      write_cnt(8'd0);
      chk("R5", "zero accepted in seq mode", load_err, 0);
      trace_en = 1'b1; in_debug = 1'b0; @(negedge clk);
      chk("R5", "no request before instruction", dbg_req, 0);
      instr();
      chk("R5", "request after one instruction", dbg_req, 1);
      in_debug = 1'b1; @(negedge clk);
      seq_bkpt_en = 1'b0;
   endtask

   task automatic t_bad_zero();
      in_debug = 1'b1; seq_bkpt_en = 1'b0;
      write_cnt(8'd0);
      chk("R6", "load_err on illegal zero", load_err, 1);
      trace_en = 1'b1; in_debug = 1'b0; @(negedge clk);
      for (int i = 0; i < 5; i++) instr();
      chk("R6", "no request after illegal zero", dbg_req, 0);
      in_debug = 1'b1; @(negedge clk);
      write_cnt(8'd2);
      chk("R6", "load_err cleared by legal write", load_err, 0);
   endtask

   task automatic t_reset_req();
      in_debug = 1'b0; trace_en = 1'b0;
      do_reset(1'b1);
      halt_on_reset = 1'b0;
      chk("R9", "request after reset", dbg_req, 1);
      chk("R9", "trace_hit stays clear", trace_hit, 0);
      idle(2);
      chk("R9", "reset request held", dbg_req, 1);
      in_debug = 1'b1; @(negedge clk);
      chk("R9", "reset request dropped in debug", dbg_req, 0);
   endtask

   initial begin
      t_reset();
      t_write_gate();
      t_hold_disabled();
      t_count(3);
      t_no_refire();
      t_count(1);
      t_sts_clr();
      t_seq_zero();
      t_bad_zero();
      t_reset_req();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 20000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule